// File: doc/BRIEF.md
# Matrix Remap Index Generator

This block replaces the plain 0,1,2,... element counter of a vector loop with a walk over an array shape of one, two or three dimensions. A 32-bit shape word gives the size of each dimension, the order in which the dimensions nest, a downward-count flag for each dimension, one dimension to leave out of the address, an index-mode flag and a base offset. The word is captured when a walk is started.

After a start, the block presents one remapped element index at a time. Each advance moves to the next combination of dimension counters, and a last flag marks the final combination. Reading a matrix transposed, mirrored or with one axis dropped therefore needs no copy, only a different shape word.

Top module: `matrix_remap_gen`

## Requirements
- R1: After reset the walk is idle: valid, last and the index output are all 0.
- R2: A start captures the shape word. Bits 5:0, 11:6 and 17:12 hold the X, Y and Z size minus one. Bits 20:18 select the order, bits 23:21 the invert flags (bit 21 for X, bit 22 for Y, bit 23 for Z), bits 25:24 the skip select, and bit 26 the index mode. Bits 31:27 hold the offset. From the cycle after the start, valid is 1 and the first combination (all counters zero) is shown.
- R3: Only advance moves the walk. The innermost dimension steps on every advance, and when it wraps from its maximum to zero it carries into the next dimension. The index stays steady while advance is low. With order 0 and no inversion, skip or offset, the indices run 0,1,2,... in sequence.
- R4: The order codes list the dimensions from innermost to outermost: 0 gives X,Y,Z, 1 gives X,Z,Y, 2 gives Y,X,Z, 3 gives Y,Z,X, 4 gives Z,X,Y and 5 gives Z,Y,X. Codes 6 and 7 act as code 0.
- R5: For a dimension whose invert flag is set, the counter value c becomes (size-1-c), so that dimension counts downward.
- R6: Skip select 1, 2 or 3 removes X, Y or Z from the index sum. That dimension is still walked. Skip 0 removes nothing.
- R7: When bit 26 is set (index mode), Z is treated as size 1 and plays no part. Only bit 18 of the order field counts: 0 makes X innermost and 1 makes Y innermost.
- R8: Last is 1 exactly while the final combination is shown. An advance taken while last is 1 ends the walk (valid goes to 0). An advance while idle has no effect.
- R9: A start during a walk restarts it at once from the first combination with the new shape word.
- R10: The index equals offset + x + y*Xsize + z*Xsize*Ysize, using the counter values after inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture shape word and begin a walk |
| advance | input | 1 | Step to the next combination |
| shapeWord | input | 32 | Packed shape descriptor |
| validOut | output | 1 | A walk is active and idxOut is meaningful |
| idxOut | output | IDX_W | Remapped element index |
| lastOut | output | 1 | Current combination is the final one |

## Verification
Every result is due one clock edge after the input that causes it. A start or an advance is registered at one rising edge, and the index, valid and last outputs are combinational from the registers. The bench drives its inputs on a falling edge and samples on the next falling edge. At each combination it compares the index against a mixed-radix decomposition of the step number. During random idle gaps it checks that the outputs do not move. After the final advance it checks that valid has dropped and that further advances change nothing.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;

  typedef struct packed {
    logic [5:0] xm1;
    logic [5:0] ym1;
    logic [5:0] zm1;
    logic [2:0] order;
    logic [2:0] inv;
    logic [1:0] skip;
    logic [4:0] offset;
  } shape_t;

  function automatic shape_t decodeShape(input logic [31:0] w);
    shape_t s;
    s.xm1    = w[5:0];
    s.ym1    = w[11:6];
    s.zm1    = w[26] ? 6'd0 : w[17:12];
    s.order  = w[26] ? (w[18] ? 3'd2 : 3'd0) : w[20:18];
    s.inv    = w[23:21];
    s.skip   = w[25:24];
    s.offset = w[31:27];
    return s;
  endfunction

  // nesting rank per dimension, 0 = innermost; element 0 is X, 1 is Y, 2 is Z
  function automatic logic [2:0][1:0] rankOf(input logic [2:0] ord);
    logic [2:0][1:0] r;
    case (ord)
      3'd1:    begin r[0] = 2'd0; r[2] = 2'd1; r[1] = 2'd2; end
      3'd2:    begin r[1] = 2'd0; r[0] = 2'd1; r[2] = 2'd2; end
      3'd3:    begin r[1] = 2'd0; r[2] = 2'd1; r[0] = 2'd2; end
      3'd4:    begin r[2] = 2'd0; r[0] = 2'd1; r[1] = 2'd2; end
      3'd5:    begin r[2] = 2'd0; r[1] = 2'd1; r[0] = 2'd2; end
      default: begin r[0] = 2'd0; r[1] = 2'd1; r[2] = 2'd2; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    advance,
  input  logic    atEnd,
  output strobe_t strb,
  output logic    running
);

  always_comb begin
    strb.load = start;
    strb.step = running && advance && !start && !atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      running <= 1'b0;
    else if (start)
      running <= 1'b1;
    else if (running && advance && atEnd)
      running <= 1'b0;
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> running); // R2

  AST_END_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (running && advance && atEnd && !start) |=> !running); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> !running); // R8

endmodule

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [31:0]      shapeWord,
  output logic [IDX_W-1:0] idx,
  output logic             atEnd
);

  localparam int NDIM = 3;

  shape_t               shp;
  logic [NDIM-1:0][5:0] cnt;
  logic [NDIM-1:0][5:0] cmax;
  logic [NDIM-1:0][5:0] eff;
  logic [NDIM-1:0][1:0] rank;
  logic [NDIM-1:0]      atMax;
  logic [NDIM-1:0]      inc;

  assign cmax[0] = shp.xm1;
  assign cmax[1] = shp.ym1;
  assign cmax[2] = shp.zm1;
  assign rank    = rankOf(shp.order);

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    logic incD;
    assign atMax[d] = (cnt[d] == cmax[d]);
    assign eff[d]   = shp.inv[d] ? (cmax[d] - cnt[d]) : cnt[d];
    always_comb begin
      incD = strb.step;
      for (int e = 0; e < NDIM; e++)
        if ((rank[e] < rank[d]) && !atMax[e]) incD = 1'b0;
    end
    assign inc[d] = incD;
  end

  assign atEnd = &atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shp <= '0;
      cnt <= '0;
    end else if (strb.load) begin
      shp <= decodeShape(shapeWord);
      cnt <= '0;
    end else begin
      for (int k = 0; k < NDIM; k++)
        if (inc[k]) cnt[k] <= atMax[k] ? 6'd0 : cnt[k] + 6'd1;
    end
  end

  logic [IDX_W-1:0] xDim, yDim, tX, tY, tZ;
  always_comb begin
    xDim = IDX_W'(shp.xm1) + IDX_W'(1);
    yDim = IDX_W'(shp.ym1) + IDX_W'(1);
    tX   = (shp.skip == 2'd1) ? '0 : IDX_W'(eff[0]);
    tY   = (shp.skip == 2'd2) ? '0 : IDX_W'(eff[1]) * xDim;
    tZ   = (shp.skip == 2'd3) ? '0 : IDX_W'(eff[2]) * xDim * yDim;
    idx  = IDX_W'(shp.offset) + tX + tY + tZ;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] <= cmax[0]) && (cnt[1] <= cmax[1]) && (cnt[2] <= cmax[2])); // R3

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> (cnt != $past(cnt))); // R3

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cnt == '0)); // R9

endmodule

// File: rtl/matrix_remap_gen.sv
module matrix_remap_gen
  import remap_pkg::*;
#(
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             advance,
  input  logic [31:0]      shapeWord,
  output logic             validOut,
  output logic [IDX_W-1:0] idxOut,
  output logic             lastOut
);

  strobe_t          strb;
  logic             running;
  logic             atEnd;
  logic [IDX_W-1:0] idxRaw;

  remap_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .advance (advance),
    .atEnd   (atEnd),
    .strb    (strb),
    .running (running)
  );

  remap_dp #(.IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shapeWord (shapeWord),
    .idx       (idxRaw),
    .atEnd     (atEnd)
  );

  assign validOut = running;
  assign idxOut   = running ? idxRaw : '0;
  assign lastOut  = running && atEnd;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (idxOut == '0 && !lastOut)); // R1

endmodule

// File: tb/matrix_remap_gen_test.sv
module matrix_remap_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] shapeWord = '0;
  logic        validOut;
  logic [19:0] idxOut;
  logic        lastOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  matrix_remap_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .advance(advance),
    .shapeWord(shapeWord), .validOut(validOut), .idxOut(idxOut), .lastOut(lastOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input int xm1, input int ym1, input int zm1,
      input int ord, input int inv, input int skp, input int im, input int off);
    logic [31:0] w;
    w = '0;
    w[5:0] = 6'(xm1); w[11:6] = 6'(ym1); w[17:12] = 6'(zm1);
    w[20:18] = 3'(ord); w[23:21] = 3'(inv); w[25:24] = 2'(skp);
    w[26] = 1'(im); w[31:27] = 5'(off);
    return w;
  endfunction

  function automatic int walkLen(input logic [31:0] w);
    int zs;
    zs = w[26] ? 1 : int'(w[17:12]) + 1;
    return (int'(w[5:0]) + 1) * (int'(w[11:6]) + 1) * zs;
  endfunction

  // mixed-radix model of step n from the requirement text
  function automatic int expIdx(input logic [31:0] w, input int n);
    int sz[3], dig[3], nest[3], val[3], ord, rem, res;
    sz[0] = int'(w[5:0]) + 1;
    sz[1] = int'(w[11:6]) + 1;
    sz[2] = w[26] ? 1 : int'(w[17:12]) + 1;
    ord = w[26] ? (w[18] ? 2 : 0) : int'(w[20:18]);
    case (ord)
      1: begin nest[0] = 0; nest[1] = 2; nest[2] = 1; end
      2: begin nest[0] = 1; nest[1] = 0; nest[2] = 2; end
      3: begin nest[0] = 1; nest[1] = 2; nest[2] = 0; end
      4: begin nest[0] = 2; nest[1] = 0; nest[2] = 1; end
      5: begin nest[0] = 2; nest[1] = 1; nest[2] = 0; end
      default: begin nest[0] = 0; nest[1] = 1; nest[2] = 2; end
    endcase
    rem = n;
    for (int k = 0; k < 3; k++) begin
      dig[nest[k]] = rem % sz[nest[k]];
      rem = rem / sz[nest[k]];
    end
    for (int k = 0; k < 3; k++)
      val[k] = w[21 + k] ? (sz[k] - 1 - dig[k]) : dig[k];
    res = int'(w[31:27]);
    if (w[25:24] != 2'd1) res += val[0];
    if (w[25:24] != 2'd2) res += val[1] * sz[0];
    if (w[25:24] != 2'd3) res += val[2] * sz[0] * sz[1];
    return res;
  endfunction

  task automatic doStart(input logic [31:0] w);
    @(negedge clk);
    shapeWord = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // walk a shape; stop early (restart test) when abortAt >= 0
  task automatic runWalk(input logic [31:0] w, input string req, input int maxGap, input int abortAt);
    int total;
    total = walkLen(w);
    doStart(w);
    for (int n = 0; n < total; n++) begin
      check({req, " valid"}, int'(validOut), 1);
      check({req, " idx"}, int'(idxOut), expIdx(w, n));
      check({req, " R8 last"}, int'(lastOut), (n == total - 1) ? 1 : 0);
      if (n == abortAt) return;
      if (maxGap > 0) begin
        int gap;
        gap = int'($urandom % 32'(maxGap + 1));
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check("R3 hold", int'(idxOut), expIdx(w, n));
        end
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    check("R8 end valid", int'(validOut), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8 actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid", int'(validOut), 0);
    check("R1 last", int'(lastOut), 0);
    check("R1 idx", int'(idxOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R8 idle advance", int'(validOut), 0);

    // R3 plain sequential 4x3x2
    runWalk(mkWord(3, 2, 1, 0, 0, 0, 0, 0), "R3", 0, -1);
    // R4 each order code, including 6 and 7
    for (int o = 0; o < 8; o++) runWalk(mkWord(2, 1, 2, o, 0, 0, 0, 0), "R4", 1, -1);
    // R5 inversions
    runWalk(mkWord(3, 2, 1, 0, 7, 0, 0, 0), "R5", 0, -1);
    runWalk(mkWord(2, 3, 0, 2, 2, 0, 0, 0), "R5", 0, -1);
    // R6 skip each dimension
    for (int s = 1; s < 4; s++) runWalk(mkWord(2, 2, 1, 0, 0, s, 0, 0), "R6", 0, -1);
    // R7 index mode: Z ignored, order bit 18 only
    runWalk(mkWord(3, 2, 5, 0, 0, 0, 1, 0), "R7", 0, -1);
    runWalk(mkWord(3, 2, 5, 5, 1, 0, 1, 2), "R7", 0, -1);
    // R8 single element: last at once
    runWalk(mkWord(0, 0, 0, 0, 0, 0, 0, 9), "R8", 0, -1);
    @(negedge clk);
    advance = 1'b1;
    repeat (2) @(negedge clk);
    advance = 1'b0;
    check("R8 idle valid", int'(validOut), 0);
    check("R8 idle idx", int'(idxOut), 0);
    // R10 long 1D walk with max offset, and a large 3D corner
    runWalk(mkWord(63, 0, 0, 0, 0, 0, 0, 31), "R10", 0, -1);
    runWalk(mkWord(63, 63, 63, 0, 7, 0, 0, 31), "R10", 0, 0);
    // R9 restart mid-walk
    runWalk(mkWord(3, 3, 1, 1, 0, 0, 0, 4), "R9", 1, 5);
    runWalk(mkWord(2, 1, 1, 3, 5, 2, 0, 1), "R9", 0, -1);
    // random shapes
    for (int r = 0; r < 40; r++) begin
      logic [31:0] w;
      w = $urandom;
      w[5:0] = 6'($urandom % 4);
      w[11:6] = 6'($urandom % 4);
      w[17:12] = 6'($urandom % 3);
      runWalk(w, "R10", 2, -1);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule